// File: doc/BRIEF.md
# Dual-Clock FIFO with Write-Side Soft Reset

This block carries data words from a write clock domain into an unrelated read clock domain. Each side has a ready/enable handshake. A word enters on a write-clock edge where the enable and ready are both high. The word at the head is shown on the read data port while read-ready is high, and it is removed on a read-clock edge where the read enable is also high.

The write domain has two reset sources: the asynchronous active-low primary reset, and a synchronous soft-reset input sampled on the write clock. Either one empties the whole FIFO, not only the write side. Both sources are merged into one write-side reset term. That term asserts the read-side reset at once and releases it after two read-clock flops, so the read pointer, its synchronizers and the read status return to empty together with the write side.

Pointers are one bit wider than the address and cross between the domains in Gray code through two-flop synchronizers. The storage contents are never cleared. Stale words are hidden only by the reset pointers.

Top module: `softrst_afifo`

## Requirements
- R1: A word on `w_data_i` is stored on a rising `wclk_i` edge where `w_en_i` and `w_rdy_o` are both high. `w_rdy_o` is low while the FIFO holds DEPTH words (default DATA_W=8, DEPTH=2).
- R2: `r_rdy_o` is high only while the FIFO is non-empty. During that time `r_data_o` shows the oldest stored word, and that word is removed on a rising `rclk_i` edge where `r_en_i` is high.
- R3: Words come out in the order they were accepted, with no loss or duplication, while both sides run at the same time on independent clocks.
- R4: Raising `r_en_i` while `r_rdy_o` is low has no effect. The next word written is the next word read.
- R5: Raising `w_en_i` while `w_rdy_o` is low has no effect. After a drain, only the words accepted earlier are read.
- R6: When `soft_rst_i` is high on a `wclk_i` edge, the write side is cleared at that edge and no word is accepted. `w_rdy_o` is high in the next write cycle, and it is still high two write cycles after the pulse ends.
- R7: A soft reset also empties the read side. From the write-clock edge that samples it, `r_rdy_o` stays low on every read-clock edge until a new word is written. Words held before the soft reset are never returned.
- R8: `rst_ni` low empties both sides asynchronously: `r_rdy_o` goes low and `w_rdy_o` goes high. After release, the FIFO works from empty.
- R9: While `r_rdy_o` is high and `r_en_i` is low, `r_data_o` and `r_rdy_o` hold steady across read-clock edges.
- R10: Each pointer that crosses between domains changes in at most one bit per clock edge. The one exception is the write pointer clearing on soft reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk_i | input | 1 | Write clock |
| rst_ni | input | 1 | Primary reset, active low, asynchronous, write domain |
| soft_rst_i | input | 1 | Soft reset, active high, synchronous to `wclk_i` |
| w_en_i | input | 1 | Write enable |
| w_data_i | input | DATA_W | Write data |
| w_rdy_o | output | 1 | Space available |
| rclk_i | input | 1 | Read clock |
| r_en_i | input | 1 | Read enable |
| r_data_o | output | DATA_W | Head word, valid while `r_rdy_o` is high |
| r_rdy_o | output | 1 | Data available |

## Verification
The properties assume that `soft_rst_i` and `w_en_i` change only just after a write-clock edge and that `r_en_i` changes only just after a read-clock edge. They also assume that both clocks run freely through every reset. The bench drives each input a short delay after its own clock edge and samples outputs on the opposite edge. It runs the read clock at twice the write rate with a phase offset, so no edges of the two domains coincide. The bench holds `r_en_i` low in the write cycle that samples a soft reset. This keeps every pop on one side of the clearing edge, so the reference queue and the design agree on which words were removed.

// File: rtl/afifo_pkg.sv
package afifo_pkg;
  localparam int unsigned SYNC_STAGES = 2;

  function automatic int unsigned ptr_width(input int unsigned depth);
    return $clog2(depth) + 1;
  endfunction
endpackage

// File: rtl/afifo_sync.sv
module afifo_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = afifo_pkg::SYNC_STAGES
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else if (clr_i) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/afifo_rst_sync.sv
// assert asynchronously, release after STAGES destination flops
module afifo_rst_sync #(
  parameter int unsigned STAGES = afifo_pkg::SYNC_STAGES
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) chain_q <= '0;
    else          chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/afifo_wptr.sv
module afifo_wptr #(
  parameter int unsigned AW = 1,
  localparam int unsigned PW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic [PW-1:0] rgray_i,
  output logic          rdy_o,
  output logic          push_o,
  output logic [AW-1:0] addr_o,
  output logic [PW-1:0] gray_o
);
  // the two top Gray bits differ when full
  localparam logic [PW-1:0] FULL_MASK = PW'(3) << (AW - 1);

  logic [PW-1:0] bin_q, gray_q, bin_nx;
  logic          full;

  assign full   = (gray_q == (rgray_i ^ FULL_MASK));
  assign push_o = en_i & ~full & ~clr_i;
  assign bin_nx = bin_q + PW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else if (clr_i) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else if (push_o) begin
      bin_q  <= bin_nx;
      gray_q <= bin_nx ^ (bin_nx >> 1);
    end
  end

  assign rdy_o  = ~full;
  assign addr_o = bin_q[AW-1:0];
  assign gray_o = gray_q;
endmodule

// File: rtl/afifo_rptr.sv
module afifo_rptr #(
  parameter int unsigned AW = 1,
  localparam int unsigned PW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [PW-1:0] wgray_i,
  output logic          rdy_o,
  output logic [AW-1:0] addr_o,
  output logic [PW-1:0] gray_o
);
  logic [PW-1:0] bin_q, gray_q, bin_nx;
  logic          empty, pop;

  assign empty  = (gray_q == wgray_i);
  assign pop    = en_i & ~empty;
  assign bin_nx = bin_q + PW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else if (pop) begin
      bin_q  <= bin_nx;
      gray_q <= bin_nx ^ (bin_nx >> 1);
    end
  end

  assign rdy_o  = ~empty;
  assign addr_o = bin_q[AW-1:0];
  assign gray_o = gray_q;
endmodule

// File: rtl/softrst_afifo.sv
module softrst_afifo #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 2,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned PW = afifo_pkg::ptr_width(DEPTH)
) (
  input  logic              wclk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              w_en_i,
  input  logic [DATA_W-1:0] w_data_i,
  output logic              w_rdy_o,
  input  logic              rclk_i,
  input  logic              r_en_i,
  output logic [DATA_W-1:0] r_data_o,
  output logic              r_rdy_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     waddr, raddr;
  logic [PW-1:0]     wgray, rgray, wgray_rs, rgray_ws;
  logic              push, wsoft_q, rrst_async_n, rrst_n;

  // registered soft reset: glitch-free source for the read-side async reset
  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) wsoft_q <= 1'b0;
    else         wsoft_q <= soft_rst_i;
  end

  assign rrst_async_n = rst_ni & ~wsoft_q;

  afifo_rst_sync i_rrst_sync (
    .clk_i  (rclk_i),
    .arst_ni(rrst_async_n),
    .rst_no (rrst_n)
  );

  afifo_wptr #(.AW(AW)) i_wptr (
    .clk_i  (wclk_i),
    .rst_ni (rst_ni),
    .clr_i  (soft_rst_i),
    .en_i   (w_en_i),
    .rgray_i(rgray_ws),
    .rdy_o  (w_rdy_o),
    .push_o (push),
    .addr_o (waddr),
    .gray_o (wgray)
  );

  afifo_sync #(.W(PW)) i_sync_r2w (
    .clk_i (wclk_i),
    .rst_ni(rst_ni),
    .clr_i (soft_rst_i),
    .d_i   (rgray),
    .q_o   (rgray_ws)
  );

  afifo_sync #(.W(PW)) i_sync_w2r (
    .clk_i (rclk_i),
    .rst_ni(rrst_n),
    .clr_i (1'b0),
    .d_i   (wgray),
    .q_o   (wgray_rs)
  );

  afifo_rptr #(.AW(AW)) i_rptr (
    .clk_i  (rclk_i),
    .rst_ni (rrst_n),
    .en_i   (r_en_i),
    .wgray_i(wgray_rs),
    .rdy_o  (r_rdy_o),
    .addr_o (raddr),
    .gray_o (rgray)
  );

  always_ff @(posedge wclk_i) begin
    if (push) mem_q[waddr] <= w_data_i;
  end

  assign r_data_o = mem_q[raddr];
endmodule

// File: rtl/softrst_afifo_chk.sv
module softrst_afifo_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PW     = 2
) (
  input logic              wclk_i,
  input logic              rclk_i,
  input logic              rst_ni,
  input logic              soft_rst_i,
  input logic              w_en_i,
  input logic              w_rdy_o,
  input logic              r_en_i,
  input logic              r_rdy_o,
  input logic [DATA_W-1:0] r_data_o,
  input logic              rrst_n,
  input logic [PW-1:0]     wgray,
  input logic [PW-1:0]     rgray
);
  p_wr_idle_r1: assert property (@(posedge wclk_i) disable iff (!rst_ni || soft_rst_i)
    (!w_en_i || !w_rdy_o) |=> $stable(wgray));

  p_soft_rdy_r6: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    soft_rst_i |=> w_rdy_o);

  p_soft_clr_r6: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    soft_rst_i |=> (wgray == '0));

  p_rd_rst_empty_r7: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !rrst_n |-> !r_rdy_o);

  p_empty_no_pop_r4: assert property (@(posedge rclk_i) disable iff (!rrst_n)
    !r_rdy_o |=> $stable(rgray));

  p_rd_hold_r9: assert property (@(posedge rclk_i) disable iff (!rrst_n)
    (r_rdy_o && !r_en_i) |=> (r_rdy_o && $stable(r_data_o)));

  p_rgray_step_r10: assert property (@(posedge rclk_i) disable iff (!rrst_n)
    $countones(rgray ^ $past(rgray)) <= 1);

  p_wgray_step_r10: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !$past(soft_rst_i) |-> ($countones(wgray ^ $past(wgray)) <= 1));
endmodule

bind softrst_afifo softrst_afifo_chk #(.DATA_W(DATA_W), .PW(PW)) i_chk (
  .wclk_i    (wclk_i),
  .rclk_i    (rclk_i),
  .rst_ni    (rst_ni),
  .soft_rst_i(soft_rst_i),
  .w_en_i    (w_en_i),
  .w_rdy_o   (w_rdy_o),
  .r_en_i    (r_en_i),
  .r_rdy_o   (r_rdy_o),
  .r_data_o  (r_data_o),
  .rrst_n    (rrst_n),
  .wgray     (wgray),
  .rgray     (rgray)
);

// File: tb/test_softrst_afifo.sv
module test_softrst_afifo;
  localparam int DW = 8;
  localparam int DEPTH = 2;

  logic          wclk, rclk, rst_n, soft_rst, w_en, r_en;
  logic [DW-1:0] w_data;
  logic          w_rdy, r_rdy;
  logic [DW-1:0] r_data;

  int n_tests = 0, n_fail = 0, n_rd = 0, rd_mode = 0, rd_cnt = 0, base = 0;
  bit done = 0;
  logic [DW-1:0] q[$];
  logic          pend_push = 0, pend_clr = 0;
  logic [DW-1:0] pend_data = '0;

  softrst_afifo #(.DATA_W(DW), .DEPTH(DEPTH)) i_softrst_afifo (
    .wclk_i(wclk), .rst_ni(rst_n), .soft_rst_i(soft_rst), .w_en_i(w_en),
    .w_data_i(w_data), .w_rdy_o(w_rdy), .rclk_i(rclk), .r_en_i(r_en),
    .r_data_o(r_data), .r_rdy_o(r_rdy)
  );

  // 50 MHz write clock; read clock twice as fast, offset so no edges coincide
  initial begin wclk = 0; forever #10 wclk = ~wclk; end
  initial begin rclk = 0; #2; forever begin rclk = 1; #5; rclk = 0; #5; end end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // reference model: decide at the negedge, apply at the clearing/storing edge
  always @(negedge wclk) begin
    pend_clr  = rst_n && soft_rst;
    pend_push = rst_n && !soft_rst && w_en && w_rdy;
    pend_data = w_data;
  end
  always @(posedge wclk) begin
    if (pend_clr) q.delete();
    else if (pend_push) q.push_back(pend_data);
    pend_clr = 0; pend_push = 0;
  end

  // every read cycle: ready implies data and head matches model
  always @(negedge rclk) begin
    if (rst_n && r_rdy) begin
      chk(q.size() > 0, "R2 ready with model empty", int'(q.size()), 1);
      if (q.size() > 0) begin
        chk(r_data == q[0], "R3 head data", int'(r_data), int'(q[0]));
        if (r_en) begin void'(q.pop_front()); n_rd++; end
      end
    end
  end

  initial begin
    r_en = 0;
    forever begin
      @(posedge rclk); #1;
      rd_cnt++;
      r_en = (rd_mode == 1) || (rd_mode == 2 && (rd_cnt % 3 != 0));
    end
  end

  task automatic wcyc(input int n);
    repeat (n) @(posedge wclk);
    #2;
  endtask

  task automatic wr(input logic [DW-1:0] d);
    @(posedge wclk); #2;
    w_en = 1; w_data = d;
    for (int i = 0; i < 1000; i++) begin
      @(negedge wclk);
      if (w_rdy) break;
    end
    @(posedge wclk); #2;
    w_en = 0;
  endtask

  task automatic soft_pulse();
    @(posedge wclk); #2; soft_rst = 1;
    @(posedge wclk); #2; soft_rst = 0;
  endtask

  initial begin
    #(20 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    rst_n = 0; soft_rst = 0; w_en = 0; w_data = '0;
    #35 rst_n = 1;
    wcyc(2);
    @(negedge wclk); chk(w_rdy == 1, "R8 reset w_rdy", w_rdy, 1);
    @(negedge rclk); chk(r_rdy == 0, "R8 reset r_rdy", r_rdy, 0);

    // R4: reads on empty do nothing
    rd_mode = 1; wcyc(6);
    @(negedge rclk); chk(r_rdy == 0, "R4 empty stays empty", r_rdy, 0);
    rd_mode = 0; wcyc(1);
    base = n_rd;
    wr(8'h11); wcyc(4);
    @(negedge rclk);
    chk(r_rdy == 1, "R2 ready after write", r_rdy, 1);
    chk(r_data == 8'h11, "R4 first word after empty reads", r_data, 8'h11);

    // R9: hold without read
    for (int i = 0; i < 4; i++) begin
      @(negedge rclk);
      chk(r_rdy && r_data == 8'h11, "R9 hold head", r_data, 8'h11);
    end

    // R1/R5: fill, then write while full
    wr(8'h22); wcyc(1);
    @(negedge wclk); chk(w_rdy == 0, "R1 full at DEPTH", w_rdy, 0);
    @(posedge wclk); #2; w_en = 1; w_data = 8'h33;
    wcyc(3); w_en = 0;
    rd_mode = 1; wcyc(6); rd_mode = 0; wcyc(1);
    chk(n_rd - base == 2, "R5 write while full dropped", n_rd - base, 2);
    @(negedge rclk); chk(r_rdy == 0, "R5 empty after drain", r_rdy, 0);
    @(negedge wclk); chk(w_rdy == 1, "R1 space after drain", w_rdy, 1);

    // R3: streaming with gapped reads
    base = n_rd; rd_mode = 2;
    for (int i = 0; i < 20; i++) wr(DW'(8'h40 + i * 3));
    wcyc(10); rd_mode = 0; wcyc(1);
    chk(n_rd - base == 20, "R3 stream count", n_rd - base, 20);

    // R6/R7: soft reset with data in flight
    wr(8'hA1); wr(8'hA2); wcyc(4);
    @(negedge rclk); chk(r_rdy == 1, "R7 data present before soft reset", r_rdy, 1);
    soft_pulse();
    @(negedge wclk); chk(w_rdy == 1, "R6 w_rdy after pulse", w_rdy, 1);
    wcyc(2);
    @(negedge wclk); chk(w_rdy == 1, "R6 w_rdy two cycles after", w_rdy, 1);
    for (int i = 0; i < 6; i++) begin
      @(negedge rclk); chk(r_rdy == 0, "R7 read side empty", r_rdy, 0);
    end
    base = n_rd; rd_mode = 1; wcyc(4);
    chk(n_rd - base == 0, "R7 no stale word", n_rd - base, 0);
    wr(8'h5A); wcyc(5); rd_mode = 0; wcyc(1);
    chk(n_rd - base == 1, "R7 new word only", n_rd - base, 1);

    // R6: soft reset while full
    wr(8'h01); wr(8'h02); wcyc(4);
    @(negedge wclk); chk(w_rdy == 0, "R1 full before soft reset", w_rdy, 0);
    soft_pulse();
    @(negedge wclk); chk(w_rdy == 1, "R6 w_rdy after full soft reset", w_rdy, 1);
    wcyc(3);
    @(negedge rclk); chk(r_rdy == 0, "R7 empty after full soft reset", r_rdy, 0);

    // R8: primary reset with data held
    wr(8'h77); wcyc(4);
    @(negedge rclk); chk(r_rdy == 1, "R8 data before reset", r_rdy, 1);
    @(posedge wclk); #2; rst_n = 0; q.delete(); #1;
    chk(r_rdy == 0, "R8 async empty", r_rdy, 0);
    chk(w_rdy == 1, "R8 async w_rdy", w_rdy, 1);
    wcyc(3); rst_n = 1; wcyc(3);
    @(negedge rclk); chk(r_rdy == 0, "R8 empty after release", r_rdy, 0);
    base = n_rd; wr(8'h88); wcyc(4);
    rd_mode = 1; wcyc(4); rd_mode = 0; wcyc(1);
    chk(n_rd - base == 1, "R8 works after release", n_rd - base, 1);

    report();
  end
endmodule